// File: doc/BRIEF.md
# Cascadable Serial Word Loader for a DAC

This block is the digital front end of a serial-input digital-to-analog converter. A host frames a transfer by pulling an active-low frame strobe low and clocks data in, most significant bit first, on the falling edges of a serial clock. The bits collect in an input shift register. A separate converter latch drives the parallel word to the converter core. That latch is loaded from the shift register only when an active-low load strobe is asserted, so a new word can be shifted in while the converter keeps its old value.

A mode pin selects one of two behaviours. In single-device mode, the block accepts exactly one word per frame and then ignores the clock until the frame closes. The serial output stays low in this mode. In cascade mode, the clock is never gated while the frame is open. Bits pushed out of the top of the shift register appear on the serial output, which drives the serial input of the next device. A chain of N devices is loaded with N words in one frame, and a shared load strobe then updates every converter at the same moment. An active-low clear input forces the converter latch to zero at once, without waiting for a clock, and leaves the shift register untouched.

All serial-side pins are brought into the system clock domain through a synchronizer of configurable depth. The serial clock must therefore stay high and stay low for at least SYNC_STAGES+2 system clock cycles in each phase. The word width is 16 bits, or 14 bits in the narrow variant.

Top module: `dacif_serial_top`

## Requirements
- R1: After reset, `dac_word` is all zeros, the shift register is all zeros and `sdout` is low.
- R2: Each falling `sclk` edge seen while `sync_n` is low and the gate is open shifts the register left by one and places `sdin` in bit 0, so the first bit sent ends up as the MSB. Rising `sclk` edges never change the register.
- R3: With `dcen` low (single-device mode), only the first WORD_W falling edges after `sync_n` falls are accepted and later edges are ignored. Closing and reopening the frame re-arms the gate. `sdout` is held low in this mode.
- R4: With `dcen` high (cascade mode), every falling edge in the frame shifts, and `sdout` shows the register MSB. The bit taken on fall k is therefore on `sdout` from fall k+WORD_W-1 until the next fall.
- R5: In a chain of N devices, each `sdout` drives the next `sdin`. Sending WORD_W×N bits in one cascade frame leaves the first device holding the last word sent and the last device holding the first word sent.
- R6: While `sync_n` is high, no `sclk` edge changes the shift register.
- R7: While `ldac_n` is low, the converter latch copies the shift register (within SYNC_STAGES+1 cycles). While `ldac_n` is high, `dac_word` keeps its value whatever is shifted.
- R8: `clr_n` low forces `dac_word` to zero without a clock edge and takes priority over `ldac_n`. The shift register keeps its content, so a later load restores it.
- R9: With WORD_W=14, all of the above holds for 14-bit words: 14 edges are accepted in single-device mode, and the chain forwards 14 bits per device.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| sclk | input | 1 | Serial clock; data taken on falling edges |
| sync_n | input | 1 | Active-low frame strobe |
| sdin | input | 1 | Serial data in, MSB first |
| dcen | input | 1 | Mode: 1 = cascade, 0 = single-device |
| ldac_n | input | 1 | Active-low latch load strobe |
| clr_n | input | 1 | Active-low asynchronous latch clear |
| sdout | output | 1 | Serial data out to next device (low in single-device mode) |
| dac_word | output | WORD_W | Converter latch contents |

## Verification
A wrong gate count shows up only after the next load strobe, as a word whose bits are offset by the number of edges that were miscounted. A corrupted shift register in cascade mode shows up on `sdout` within WORD_W falling edges, and the chain places it in a neighbour's word. The bench sweeps several word patterns through a three-device chain. It compares every forwarded bit and every latched word against values it computes arithmetically. It also covers short frames, clocks outside a frame, a load coinciding with a clear, and the 14-bit variant.

// File: rtl/dacif_pkg.sv
package dacif_pkg;

   typedef enum logic {
      MODE_GATED = 1'b0,
      MODE_CHAIN = 1'b1
   } shift_mode_e;

   function automatic int count_width(input int bits);
      return $clog2(bits + 1);
   endfunction

endpackage

// File: rtl/dacif_sync.sv
module dacif_sync #(
   parameter int           W       = 1,
   parameter int           STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("dacif_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         logic [W-1:0] r;
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) r <= RST_VAL;
               else        r <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) r <= RST_VAL;
               else        r <= g_stage[i-1].r;
            end
         end
      end
   endgenerate

   assign q = g_stage[STAGES-1].r;

endmodule

// File: rtl/dacif_shifter.sv
module dacif_shifter
   import dacif_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int CNT_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_s,
   input  logic              sync_n_s,
   input  logic              sdin_s,
   input  shift_mode_e       mode,
   output logic [WORD_W-1:0] shift_q,
   output logic [CNT_W-1:0]  acc_cnt,
   output logic              sclk_fall,
   output logic              sdout
);

   localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

   logic sclk_d;
   logic gate_open;
   logic shift_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_d <= 1'b1;
      else        sclk_d <= sclk_s;
   end

   assign sclk_fall = sclk_d & ~sclk_s;

   // edge counter for the current frame, saturating at one word
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         acc_cnt <= '0;
      else if (sync_n_s)                  acc_cnt <= '0;
      else if (sclk_fall && acc_cnt != FULL) acc_cnt <= acc_cnt + 1'b1;
   end

   always_comb begin
      unique case (mode)
         MODE_CHAIN: gate_open = 1'b1;
         default:    gate_open = (acc_cnt < FULL);
      endcase
   end

   assign shift_en = sclk_fall & ~sync_n_s & gate_open;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        shift_q <= '0;
      else if (shift_en) shift_q <= {shift_q[WORD_W-2:0], sdin_s};
   end

   assign sdout = (mode == MODE_CHAIN) ? shift_q[WORD_W-1] : 1'b0;

endmodule

// File: rtl/dacif_latch.sv
module dacif_latch #(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_n,
   input  logic              load,
   input  logic [WORD_W-1:0] din,
   output logic [WORD_W-1:0] dout
);

   logic arst_n;

   assign arst_n = rst_n & clr_n;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)   dout <= '0;
      else if (load) dout <= din;
   end

endmodule

// File: rtl/dacif_serial_top.sv
module dacif_serial_top
   import dacif_pkg::*;
#(
   parameter int WORD_W      = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk,
   input  logic              sync_n,
   input  logic              sdin,
   input  logic              dcen,
   input  logic              ldac_n,
   input  logic              clr_n,
   output logic              sdout,
   output logic [WORD_W-1:0] dac_word
);

   localparam int CNT_W = count_width(WORD_W);
   localparam int NPIN  = 5;
   // bit order: {dcen, ldac_n, sdin, sync_n, sclk}
   localparam logic [NPIN-1:0] PIN_IDLE = 5'b0_1_0_1_1;

   generate
      if (!(WORD_W == 14 || WORD_W == 16)) begin : g_bad_width
         $error("dacif_serial_top: WORD_W must be 14 or 16");
      end
   endgenerate

   logic [NPIN-1:0]   pins_s;
   logic              sclk_s, sync_n_s, sdin_s, ldac_n_s, dcen_s;
   logic              latch_load;
   logic              sclk_fall;
   logic [WORD_W-1:0] shift_q;
   logic [CNT_W-1:0]  acc_cnt;
   shift_mode_e       mode;

   dacif_sync #(
      .W       (NPIN),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (PIN_IDLE)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({dcen, ldac_n, sdin, sync_n, sclk}),
      .q     (pins_s)
   );

   assign {dcen_s, ldac_n_s, sdin_s, sync_n_s, sclk_s} = pins_s;
   assign mode       = shift_mode_e'(dcen_s);
   assign latch_load = ~ldac_n_s;

   dacif_shifter #(
      .WORD_W (WORD_W),
      .CNT_W  (CNT_W)
   ) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .sclk_s    (sclk_s),
      .sync_n_s  (sync_n_s),
      .sdin_s    (sdin_s),
      .mode      (mode),
      .shift_q   (shift_q),
      .acc_cnt   (acc_cnt),
      .sclk_fall (sclk_fall),
      .sdout     (sdout)
   );

   dacif_latch #(
      .WORD_W (WORD_W)
   ) u_latch (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_n (clr_n),
      .load  (latch_load),
      .din   (shift_q),
      .dout  (dac_word)
   );

endmodule

// File: rtl/dacif_checker.sv
module dacif_checker #(
   parameter int WORD_W = 16,
   parameter int CNT_W  = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              clr_n,
   input logic              sclk_fall,
   input logic              sync_n_s,
   input logic              dcen_s,
   input logic              sdin_s,
   input logic              load,
   input logic [WORD_W-1:0] sr_q,
   input logic [WORD_W-1:0] dac_word,
   input logic [CNT_W-1:0]  acc_cnt
);

   localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

   p_no_shift_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !sclk_fall |=> $stable(sr_q));

   p_gate_closed_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!dcen_s && acc_cnt == FULL) |=> $stable(sr_q));

   p_chain_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk_fall && !sync_n_s && dcen_s) |=>
         (sr_q == {$past(sr_q[WORD_W-2:0]), $past(sdin_s)}));

   p_frame_closed_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sync_n_s |=> $stable(sr_q));

   p_load_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (load && clr_n) |=> (!clr_n || dac_word == $past(sr_q)));

   p_latch_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> (!clr_n || dac_word == $past(dac_word)));

   p_clear_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_n |-> (dac_word == '0));

endmodule

bind dacif_serial_top dacif_checker #(
   .WORD_W (WORD_W),
   .CNT_W  (CNT_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .clr_n     (clr_n),
   .sclk_fall (sclk_fall),
   .sync_n_s  (sync_n_s),
   .dcen_s    (dcen_s),
   .sdin_s    (sdin_s),
   .load      (latch_load),
   .sr_q      (shift_q),
   .dac_word  (dac_word),
   .acc_cnt   (acc_cnt)
);

// File: tb/tb_dacif_serial_top.sv
module tb_dacif_serial_top;

   localparam int H = 4;   // system cycles per serial clock phase

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sclk = 1'b1, sync_n = 1'b1, sdin = 1'b0, dcen = 1'b0;
   logic ldac_n = 1'b1, clr_n = 1'b1;

   logic        so0, so1, so2, t_so0, t_so1;
   logic [15:0] w0, w1, w2;
   logic [13:0] t0, t1;

   int checks = 0, fails = 0, falls = 0;
   logic last_so;
   bit   done = 0;

   always #2 clk = ~clk;

   dacif_serial_top #(.WORD_W(16)) dut  (.clk, .rst_n, .sclk, .sync_n, .sdin(sdin), .dcen,
      .ldac_n, .clr_n, .sdout(so0), .dac_word(w0));
   dacif_serial_top #(.WORD_W(16)) dut1 (.clk, .rst_n, .sclk, .sync_n, .sdin(so0), .dcen,
      .ldac_n, .clr_n, .sdout(so1), .dac_word(w1));
   dacif_serial_top #(.WORD_W(16)) dut2 (.clk, .rst_n, .sclk, .sync_n, .sdin(so1), .dcen,
      .ldac_n, .clr_n, .sdout(so2), .dac_word(w2));
   dacif_serial_top #(.WORD_W(14)) dut14a (.clk, .rst_n, .sclk, .sync_n, .sdin(sdin), .dcen,
      .ldac_n, .clr_n, .sdout(t_so0), .dac_word(t0));
   dacif_serial_top #(.WORD_W(14)) dut14b (.clk, .rst_n, .sclk, .sync_n, .sdin(t_so0), .dcen,
      .ldac_n, .clr_n, .sdout(t_so1), .dac_word(t1));

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse(input logic b);
      sdin = b;
      wait_cyc(H);
      sclk = 1'b0;
      falls++;
      wait_cyc(H);
      last_so = so0;
      sclk = 1'b1;
   endtask

   task automatic send(input logic [15:0] v, input int nbits);
      for (int i = nbits - 1; i >= 0; i--) pulse(v[i]);
   endtask

   task automatic open_frame();
      sync_n = 1'b0; falls = 0; wait_cyc(H);
   endtask

   task automatic close_frame();
      wait_cyc(H); sync_n = 1'b1; wait_cyc(H);
   endtask

   task automatic load_pulse();
      ldac_n = 1'b0; wait_cyc(H); ldac_n = 1'b1; wait_cyc(2 * H);
   endtask

   function automatic logic [15:0] pat(input int k, input int d);
      return 16'((k * 40503 + d * 9973) ^ 16'h5A3C);
   endfunction

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin : stim
      logic [15:0] a, b, c, g, e0, e1, e2;
      wait_cyc(5);
      rst_n = 1'b1;
      wait_cyc(3);

      // R1 reset state
      chk("R1 w0", w0, 16'h0); chk("R1 w1", w1, 16'h0); chk("R1 w2", w2, 16'h0);
      chk("R1 t0", 16'(t0), 16'h0); chk("R1 sdout", 16'(so0), 16'h0);

      // R3 gated mode: one word accepted, extra edges ignored, sdout low
      dcen = 1'b0; wait_cyc(H);
      a = 16'hC3A5;
      open_frame();
      send(a, 16);
      for (int i = 0; i < 5; i++) begin
         pulse(1'b1);
         chk("R3 sdout low", 16'(last_so), 16'h0);
      end
      close_frame();
      chk("R7 latch holds before load", w0, 16'h0);
      load_pulse();
      chk("R3 gated word", w0, a);
      chk("R3 downstream sees low sdout", w1, 16'h0);
      chk("R2 dut2 zero", w2, 16'h0);

      // R2/R3 short frame then re-armed full frame
      b = 16'h005E;
      open_frame(); send(b, 8); close_frame();
      load_pulse();
      chk("R2 short frame", w0, 16'((a << 8) | b[7:0]));
      c = 16'h1F08;
      open_frame(); send(c, 16); pulse(1'b1); close_frame();
      load_pulse();
      chk("R3 rearm", w0, c);

      // R4/R5/R6/R7 cascade sweep
      dcen = 1'b1; wait_cyc(H);
      e0 = c; e1 = 16'h0; e2 = 16'h0;
      for (int p = 0; p < 8; p++) begin
         logic [15:0] x0, x1, x2;
         x0 = pat(p, 0); x1 = pat(p, 1); x2 = pat(p, 2);
         open_frame();
         send(x0, 16);
         chk("R4 sdout after fall 16", 16'(last_so), 16'(x0[15]));
         for (int i = 15; i >= 1; i--) begin
            pulse(x1[i]);
            chk("R4 forwarded bit", 16'(last_so), 16'(x0[i-1]));
         end
         pulse(x1[0]);
         send(x2, 16);
         close_frame();
         for (int i = 0; i < 6; i++) pulse(1'b1);   // R6 edges with frame closed
         chk("R7 hold w0", w0, e0); chk("R7 hold w1", w1, e1); chk("R7 hold w2", w2, e2);
         load_pulse();
         chk("R5 first device", w0, x2);
         chk("R5 middle device", w1, x1);
         chk("R6 last device", w2, x0);
         e0 = x2; e1 = x1; e2 = x0;
      end

      // R8 clear beats load, shift register kept
      ldac_n = 1'b0;
      @(negedge clk); clr_n = 1'b0; #1;
      chk("R8 async w0", w0, 16'h0); chk("R8 async w2", w2, 16'h0);
      wait_cyc(2 * H);
      chk("R8 priority over load", w1, 16'h0);
      ldac_n = 1'b1; wait_cyc(2 * H);
      clr_n = 1'b1; wait_cyc(2 * H);
      chk("R8 stays clear", w0, 16'h0);
      load_pulse();
      chk("R8 restore w0", w0, e0); chk("R8 restore w1", w1, e1); chk("R8 restore w2", w2, e2);

      // R9 14-bit variant, gated then cascade
      dcen = 1'b0; wait_cyc(H);
      g = 16'hB6D9;
      open_frame(); send(g, 16); close_frame();
      load_pulse();
      chk("R9 gated 14", 16'(t0), 16'(g >> 2));
      chk("R9 gated 14 downstream", 16'(t1), 16'h0);
      dcen = 1'b1; wait_cyc(H);
      for (int p = 0; p < 3; p++) begin
         logic [13:0] y0, y1;
         y0 = 14'(pat(p, 7)); y1 = 14'(pat(p, 9));
         open_frame(); send(16'(y0), 14); send(16'(y1), 14); close_frame();
         load_pulse();
         chk("R9 chain head", 16'(t0), 16'(y1));
         chk("R9 chain tail", 16'(t1), 16'(y0));
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule